// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffers

This block sits next to a first-level cache and holds lines fetched ahead of demand. It is built from several independent FIFO lanes. Each lane follows one sequential stream of line addresses. When the cache misses on a line that no lane can supply, the least recently used lane is flushed and restarted at the following line. It then keeps a fixed number of upcoming lines requested from a pipelined next-level memory. That memory accepts one request per cycle and answers in request order. Prefetched lines stay in the lanes and are never written into the cache by this block. The missed line itself is fetched on the cache's own demand path.

The cache presents each miss on `miss_valid_i`/`miss_addr_i`. The answer comes back in the same cycle, and there are three possible outcomes:
- `hit_o`: the line is supplied on `hit_data_o` and the lane advances.
- `wait_o`: a lane head holds the line, but its data is still in flight. The requester keeps the miss asserted until `hit_o`.
- Neither: the line is in no lane, and a lane is reassigned.

Interleaved streams, for example instruction and data walks, each occupy their own lane.

Top module: `stream_prefetch`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `hit_o`, `wait_o` and `mem_req_valid_o` are 0. No lane holds a line after reset, so a first miss to any address takes the R2 path.
- R2: A miss whose line matches no lane head gives `hit_o`=0 and `wait_o`=0 in that cycle. At the next edge the R7 victim lane is flushed, restarted with its head at the miss line + 1, and its generation advanced.
- R3: Each lane requests its lines in ascending address order, one per cycle, without waiting for data, until DEPTH lines are outstanding or held.
  - After a restart at line A, the requests for A+1 .. A+DEPTH appear on the DEPTH consecutive cycles following the restart edge, provided no lower-numbered lane is requesting.
  - The lowest-numbered requesting lane wins.
  - Each request carries its lane number and generation.
- R4: A miss whose line equals a lane head with data present gives `hit_o`=1 in the same cycle, with that line's data on `hit_data_o`. At the next edge the head is popped, and the lane queues the line after its last one.
- R5: A miss whose line equals a lane head without data yet gives `wait_o`=1 and `hit_o`=0. It causes no flush. The same request held later turns into `hit_o` once the data has arrived.
- R6: Only lane heads are compared. A miss on a line held deeper in a lane is handled as in R2, and the other lanes' contents are unaffected.
- R7: The flush victim is the lane least recently restarted or hit. After reset the order from least to most recent is lane 0, 1, 2 ...
- R8: A response with a generation other than the lane's current one is dropped. Any other response fills the oldest unfilled entry of its lane.
- R9: Several lanes track interleaved sequential streams independently. After the first miss of each stream, every later line of both streams is a head hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| miss_valid_i | input | 1 | cache miss presented |
| miss_addr_i | input | ADDR_W | missed line address |
| hit_o | output | 1 | line supplied from a lane head |
| wait_o | output | 1 | head matches, data in flight; hold the miss |
| hit_data_o | output | DATA_W | line data when `hit_o` |
| mem_req_valid_o | output | 1 | prefetch request to next level |
| mem_req_addr_o | output | ADDR_W | requested line address |
| mem_req_buf_o | output | $clog2(NUM_BUF) | requesting lane |
| mem_req_gen_o | output | GEN_W | lane generation at issue |
| mem_rsp_valid_i | input | 1 | in-order response |
| mem_rsp_buf_i | input | $clog2(NUM_BUF) | lane echoed from the request |
| mem_rsp_gen_i | input | GEN_W | generation echoed from the request |
| mem_rsp_data_i | input | DATA_W | line data |

## Verification
A lane restart can land in the same cycle as responses still returning for that lane's previous stream. The bench provokes this with five back-to-back misses to distinct streams against a six-cycle memory, so the oldest lane is flushed while three of its requests are still in flight. The fifth miss's stream is then judged by its first head hit: the supplied data must be the new line's, never a stale one. The other overlap, a pop together with a fill and a new request on one lane, is judged by the long interleaved two-stream walk, where every hit's data must match its address.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SBUF_ADDR_W  = 16;
  localparam int unsigned SBUF_DATA_W  = 32;
  localparam int unsigned SBUF_NUM_BUF = 4;
  localparam int unsigned SBUF_DEPTH   = 4;  // power of two, >= 2
  localparam int unsigned SBUF_GEN_W   = 2;
endpackage

// File: rtl/sbuf_lane.sv
module sbuf_lane #(
  parameter int unsigned DEPTH  = sbuf_pkg::SBUF_DEPTH,
  parameter int unsigned ADDR_W = sbuf_pkg::SBUF_ADDR_W,
  parameter int unsigned DATA_W = sbuf_pkg::SBUF_DATA_W,
  parameter int unsigned GEN_W  = sbuf_pkg::SBUF_GEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              pop_i,
  input  logic              issue_i,
  input  logic              rsp_we_i,
  input  logic [GEN_W-1:0]  rsp_gen_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_ready_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              need_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [GEN_W-1:0]  gen_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic              valid_q;
  logic [ADDR_W-1:0] base_q;   // line address of the head entry
  logic [PW-1:0]     head_q;
  logic [CW-1:0]     nreq_q;   // entries requested, counted from head
  logic [CW-1:0]     nret_q;   // entries filled, counted from head
  logic [GEN_W-1:0]  gen_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              rsp_ok;
  logic [PW-1:0]     wr_idx;

  assign rsp_ok = rsp_we_i && valid_q && !alloc_i && (rsp_gen_i == gen_q);
  assign wr_idx = head_q + nret_q[PW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      head_q  <= '0;
      nreq_q  <= '0;
      nret_q  <= '0;
      gen_q   <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      base_q  <= alloc_addr_i + ADDR_W'(1);
      head_q  <= '0;
      nreq_q  <= '0;
      nret_q  <= '0;
      gen_q   <= gen_q + GEN_W'(1);
    end else begin
      base_q <= base_q + ADDR_W'(pop_i);
      head_q <= head_q + PW'(pop_i);
      nreq_q <= nreq_q + CW'(issue_i) - CW'(pop_i);
      nret_q <= nret_q + CW'(rsp_ok) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rsp_ok) mem_q[wr_idx] <= rsp_data_i;
  end

  assign valid_o      = valid_q;
  assign head_addr_o  = base_q;
  assign head_ready_o = (nret_q != '0);
  assign head_data_o  = mem_q[head_q];
  assign need_o       = valid_q && (nreq_q < CW'(DEPTH));
  assign req_addr_o   = base_q + ADDR_W'(nreq_q);
  assign gen_o        = gen_q;
endmodule

// File: rtl/sbuf_lru.sv
module sbuf_lru #(
  parameter int unsigned N = sbuf_pkg::SBUF_NUM_BUF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [$clog2(N)-1:0] touch_idx_i,
  output logic [$clog2(N)-1:0] victim_o
);
  localparam int unsigned AW = $clog2(N);

  logic [AW-1:0] age_q [N];

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        age_q[g] <= AW'(N - 1 - g);
      else if (touch_i) begin
        if (touch_idx_i == AW'(g))           age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx_i]) age_q[g] <= age_q[g] + AW'(1);
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == AW'(N - 1)) victim_o = AW'(i);
  end
endmodule

// File: rtl/sbuf_pick.sv
module sbuf_pick #(
  parameter int unsigned N = sbuf_pkg::SBUF_NUM_BUF
) (
  input  logic [N-1:0]         req_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = ($clog2(N))'(i);
      end
  end
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int unsigned ADDR_W  = sbuf_pkg::SBUF_ADDR_W,
  parameter int unsigned DATA_W  = sbuf_pkg::SBUF_DATA_W,
  parameter int unsigned NUM_BUF = sbuf_pkg::SBUF_NUM_BUF,
  parameter int unsigned DEPTH   = sbuf_pkg::SBUF_DEPTH,
  parameter int unsigned GEN_W   = sbuf_pkg::SBUF_GEN_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       miss_valid_i,
  input  logic [ADDR_W-1:0]          miss_addr_i,
  output logic                       hit_o,
  output logic                       wait_o,
  output logic [DATA_W-1:0]          hit_data_o,
  output logic                       mem_req_valid_o,
  output logic [ADDR_W-1:0]          mem_req_addr_o,
  output logic [$clog2(NUM_BUF)-1:0] mem_req_buf_o,
  output logic [GEN_W-1:0]           mem_req_gen_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [$clog2(NUM_BUF)-1:0] mem_rsp_buf_i,
  input  logic [GEN_W-1:0]           mem_rsp_gen_i,
  input  logic [DATA_W-1:0]          mem_rsp_data_i
);
  localparam int unsigned BW = $clog2(NUM_BUF);

  logic [NUM_BUF-1:0] valid, ready, need, match, need_m;
  logic [ADDR_W-1:0]  head_addr [NUM_BUF];
  logic [ADDR_W-1:0]  req_addr  [NUM_BUF];
  logic [DATA_W-1:0]  head_data [NUM_BUF];
  logic [GEN_W-1:0]   gen       [NUM_BUF];

  logic          any_match, alloc, hit, grant_any;
  logic [BW-1:0] match_idx, victim, grant_idx;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_lane
    sbuf_lane #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GEN_W(GEN_W)
    ) u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc && (victim == BW'(g))),
      .alloc_addr_i (miss_addr_i),
      .pop_i        (hit && (match_idx == BW'(g))),
      .issue_i      (grant_any && (grant_idx == BW'(g))),
      .rsp_we_i     (mem_rsp_valid_i && (mem_rsp_buf_i == BW'(g))),
      .rsp_gen_i    (mem_rsp_gen_i),
      .rsp_data_i   (mem_rsp_data_i),
      .valid_o      (valid[g]),
      .head_addr_o  (head_addr[g]),
      .head_ready_o (ready[g]),
      .head_data_o  (head_data[g]),
      .need_o       (need[g]),
      .req_addr_o   (req_addr[g]),
      .gen_o        (gen[g])
    );
    assign match[g]  = valid[g] && (head_addr[g] == miss_addr_i);
    // a lane being restarted this cycle does not issue under its old stream
    assign need_m[g] = need[g] && !(alloc && (victim == BW'(g)));
  end

  sbuf_pick #(.N(NUM_BUF)) u_match (.req_i(match),  .any_o(any_match), .idx_o(match_idx));
  sbuf_pick #(.N(NUM_BUF)) u_arb   (.req_i(need_m), .any_o(grant_any), .idx_o(grant_idx));

  assign hit   = miss_valid_i && any_match && ready[match_idx];
  assign alloc = miss_valid_i && !any_match;

  sbuf_lru #(.N(NUM_BUF)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (hit || alloc),
    .touch_idx_i (hit ? match_idx : victim),
    .victim_o    (victim)
  );

  assign hit_o           = hit;
  assign wait_o          = miss_valid_i && any_match && !ready[match_idx];
  assign hit_data_o      = head_data[match_idx];
  assign mem_req_valid_o = grant_any;
  assign mem_req_addr_o  = req_addr[grant_idx];
  assign mem_req_buf_o   = grant_idx;
  assign mem_req_gen_o   = gen[grant_idx];
endmodule

// File: rtl/stream_prefetch_chk.sv
module stream_prefetch_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned GEN_W   = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       miss_valid_i,
  input logic [ADDR_W-1:0]          miss_addr_i,
  input logic                       hit_o,
  input logic                       wait_o,
  input logic                       mem_req_valid_o,
  input logic [ADDR_W-1:0]          mem_req_addr_o,
  input logic [$clog2(NUM_BUF)-1:0] mem_req_buf_o,
  input logic [GEN_W-1:0]           mem_req_gen_o
);
  // R4 / R5: one outcome at most
  p_one_outcome_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && wait_o));

  // R2: no outcome without a presented miss
  p_quiet_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |-> (!hit_o && !wait_o));

  // R3: a lane's back-to-back requests step by one line
  p_req_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && $past(mem_req_valid_o) && !$past(miss_valid_i) &&
     mem_req_buf_o == $past(mem_req_buf_o) && mem_req_gen_o == $past(mem_req_gen_o))
    |-> (mem_req_addr_o == $past(mem_req_addr_o) + ADDR_W'(1)));

  // R5: a waiting request held unchanged stays matched
  p_wait_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && $past(miss_valid_i) && $past(wait_o) &&
     miss_addr_i == $past(miss_addr_i)) |-> (hit_o || wait_o));
endmodule

bind stream_prefetch stream_prefetch_chk #(
  .ADDR_W(ADDR_W), .NUM_BUF(NUM_BUF), .GEN_W(GEN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miss_valid_i(miss_valid_i), .miss_addr_i(miss_addr_i),
  .hit_o(hit_o), .wait_o(wait_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_addr_o(mem_req_addr_o), .mem_req_buf_o(mem_req_buf_o), .mem_req_gen_o(mem_req_gen_o)
);

// File: tb/stream_prefetch_test.sv
module stream_prefetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, NB = 4, DP = 4, GW = 2, BW = 2;
  localparam int LAT = 6;
  localparam int NTBL = 12;
  // {expect_hit, line}: two interleaved streams
  localparam logic [16:0] TBL [NTBL] = '{
    {1'b0, 16'h0100}, {1'b0, 16'h0800}, {1'b1, 16'h0101}, {1'b1, 16'h0801},
    {1'b1, 16'h0102}, {1'b1, 16'h0802}, {1'b1, 16'h0103}, {1'b1, 16'h0803},
    {1'b1, 16'h0104}, {1'b1, 16'h0804}, {1'b1, 16'h0105}, {1'b1, 16'h0805}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic hit_s, wait_s, req_valid, rsp_valid;
  logic [DW-1:0] hit_data, rsp_data;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_buf, rsp_buf;
  logic [GW-1:0] req_gen, rsp_gen;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prefetch #(.ADDR_W(AW), .DATA_W(DW), .NUM_BUF(NB), .DEPTH(DP), .GEN_W(GW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
    .hit_o(hit_s), .wait_o(wait_s), .hit_data_o(hit_data),
    .mem_req_valid_o(req_valid), .mem_req_addr_o(req_addr), .mem_req_buf_o(req_buf),
    .mem_req_gen_o(req_gen), .mem_rsp_valid_i(rsp_valid), .mem_rsp_buf_i(rsp_buf),
    .mem_rsp_gen_i(rsp_gen), .mem_rsp_data_i(rsp_data));

  // pipelined in-order memory, data = {~line, line}
  logic          pv [LAT];
  logic [AW-1:0] pa [LAT];
  logic [BW-1:0] pb [LAT];
  logic [GW-1:0] pg [LAT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        pv[i] <= 1'b0; pa[i] <= '0; pb[i] <= '0; pg[i] <= '0;
      end
    end else begin
      pv[0] <= req_valid; pa[0] <= req_addr; pb[0] <= req_buf; pg[0] <= req_gen;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; pb[i] <= pb[i-1]; pg[i] <= pg[i-1];
      end
    end
  end
  assign rsp_valid = pv[LAT-1];
  assign rsp_buf   = pb[LAT-1];
  assign rsp_gen   = pg[LAT-1];
  assign rsp_data  = {~pa[LAT-1], pa[LAT-1]};

  function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; miss_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!hit_s && !wait_s && !req_valid, "R1 reset outputs", {hit_s, wait_s, req_valid}, 0);
    rst_n = 1'b1;
    #1;
    chk(!req_valid, "R1 no request after reset", req_valid, 0);
  endtask

  task automatic idle();
    @(negedge clk); miss_valid = 1'b0; #1;
  endtask

  task automatic exp_miss(input logic [AW-1:0] a, input string req);
    @(negedge clk); miss_valid = 1'b1; miss_addr = a; #1;
    chk(!hit_s && !wait_s, req, {hit_s, wait_s}, 0);
  endtask

  task automatic exp_hit(input logic [AW-1:0] a, input string req);
    bit done = 1'b0;
    @(negedge clk); miss_valid = 1'b1; miss_addr = a; #1;
    for (int n = 0; n < 30 && !done; n++) begin
      if (hit_s || !wait_s) done = 1'b1;
      else begin @(negedge clk); #1; end
    end
    chk(hit_s, req, hit_s, 1);
    if (hit_s) chk(hit_data == line_data(a), req, hit_data, line_data(a));
  endtask

  task automatic run();
    // phase 1: restart, request burst, wait, head-only compare
    do_reset();
    exp_miss(16'h0300, "R2 first miss");
    for (int k = 1; k <= DP; k++) begin
      idle();
      chk(req_valid && req_addr == AW'(16'h0300 + k) && req_buf == 0,
          "R3 burst request", {req_valid, req_addr}, {1'b1, AW'(16'h0300 + k)});
    end
    @(negedge clk); miss_valid = 1'b1; miss_addr = 16'h0301; #1;
    chk(!req_valid, "R3 lane full stops requests", req_valid, 0);
    chk(wait_s && !hit_s, "R5 head without data waits", {wait_s, hit_s}, 2'b10);
    exp_hit(16'h0301, "R4 hit after wait");
    exp_miss(16'h0303, "R6 deeper line is a miss");
    exp_hit(16'h0302, "R6 lane intact after deep miss");
    exp_hit(16'h0303, "R4 next head after pop");
    idle();

    // phase 2: two interleaved streams from a table
    do_reset();
    for (int i = 0; i < NTBL; i++) begin
      if (TBL[i][16]) exp_hit(TBL[i][15:0], "R9 interleaved head hit");
      else            exp_miss(TBL[i][15:0], "R9 R1 first miss of stream");
    end
    idle();

    // phase 3: LRU order and stale responses after a restart
    do_reset();
    exp_miss(16'h1000, "R2 lane 0");
    exp_miss(16'h2000, "R2 lane 1");
    exp_miss(16'h3000, "R2 lane 2");
    exp_miss(16'h4000, "R2 lane 3");
    exp_miss(16'h5000, "R7 evicts lane 0 with fills in flight");
    exp_hit(16'h5001, "R8 stale fills dropped");
    exp_miss(16'h1001, "R7 oldest stream evicted");
    exp_hit(16'h3001, "R7 recent lane kept");
    exp_hit(16'h4001, "R7 recent lane kept");
    exp_miss(16'h2001, "R7 lane 1 evicted by earlier miss");
    idle();
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule